// File: doc/BRIEF.md
# Video-Line Interrupt Counter with Address-Bit Edge Filter

This block sits on the cartridge side of a game system. It watches the video processor's address bus and counts rising edges of one address bit (bit 12). Each edge stands for one rendered line. Line edges are spaced far apart, but within a single line the bit toggles quickly during fetches. A rising edge therefore counts only when the bit has been low for a minimum number of CPU cycles just before it. This filter keeps closely spaced toggles from being counted more than once.

The block runs on the CPU clock and samples the video address on every cycle. Software programs a reload value and can request a reload. It can also enable interrupts, or disable and acknowledge them. On each counted edge the counter is either reloaded or decremented. When the count reaches zero with interrupts enabled, the block raises a level interrupt request and holds it until software acknowledges it.

Top module: `line_irq_timer`

## Requirements
- R1: After reset, `irq_req` is low, the counter, reload value and reload request are zero, interrupts are disabled and no low-time history is held.
- R2: A cycle with `vaddr[12]` high counts as an edge only if `vaddr[12]` was low on at least the 3 immediately preceding consecutive cycles. Two or fewer low cycles before a high cycle give no edge.
- R3: A cycle with `vaddr[12]` high always discards the low-time history, so only the first high cycle of a run can count.
- R4: On a counted edge the counter loads the reload value if the counter is zero or a reload request is pending.
- R5: On a counted edge where R4 does not apply, the counter decreases by one.
- R6: A write with `wr_sel`=1 sets the reload request. A counted edge clears it; if a strobe write and an edge fall in the same cycle, the request ends up set.
- R7: If the counter is zero after a counted edge and interrupts are enabled, `irq_req` rises in the next cycle and stays high until acknowledged. The enable value in effect before that cycle's write is the one used.
- R8: A write with `wr_sel`=2 clears the enable and drops `irq_req`; this wins over an interrupt raised in the same cycle. A write with `wr_sel`=3 sets the enable.
- R9: A write with `wr_sel`=0 stores `wr_data` as the reload value, used by edges in later cycles. Address bits other than bit 12 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous reset, active high |
| vaddr | input | 14 | Video address bus, sampled every cycle |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 reload value, 1 reload request, 2 disable/acknowledge, 3 enable |
| wr_data | input | 8 | Write data (used by target 0) |
| irq_req | output | 1 | Interrupt request, active high, level |

## Verification
The assertions check several rules on every cycle. No edge is counted unless the three prior cycles were low, and never on a second consecutive high cycle. Reload and decrement give the right counter value on each counted edge. The reload request clears after an edge. An acknowledge always drops the request, and the interrupt rises only after a counted edge. The bench's scenarios are needed to show that the right edge finally raises the interrupt. They also cover how writes interact with an edge in the same cycle, and that other address bits have no effect. These depend on sequences of writes and address patterns that only the reference model follows over many cycles.

// File: rtl/line_irq_pkg.sv
package line_irq_pkg;

  typedef enum logic [1:0] {
    SEL_RELOAD_VAL = 2'd0,
    SEL_RELOAD_REQ = 2'd1,
    SEL_IRQ_OFF    = 2'd2,
    SEL_IRQ_ON     = 2'd3
  } wr_sel_e;

  // Counter value after a counted edge.
  function automatic logic [7:0] next_count(input logic [7:0] cnt,
                                            input logic [7:0] reload_val,
                                            input logic       reload_pend);
    if (cnt == 8'd0 || reload_pend) return reload_val;
    return cnt - 8'd1;
  endfunction

  // Saturating increment of the low-age tracker.
  function automatic logic [3:0] age_step(input logic [3:0] age,
                                          input logic [3:0] limit);
    if (age >= limit) return limit;
    return age + 4'd1;
  endfunction

endpackage

// File: rtl/line_edge_filter.sv
module line_edge_filter #(
  parameter int ADDR_W    = 14,
  parameter int WATCH_BIT = 12,
  parameter int MIN_LOW   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] vaddr,
  output logic              qual_edge
);
  import line_irq_pkg::*;

  localparam logic [3:0] AGE_LIM = 4'(MIN_LOW);

  logic       bit_hi;
  logic       low_held;
  logic [3:0] low_age;
  logic       hi_prev;

  assign bit_hi    = vaddr[WATCH_BIT];
  assign qual_edge = bit_hi && low_held && (low_age >= AGE_LIM);

  always_ff @(posedge clk) begin
    if (rst) begin
      low_held <= 1'b0;
      low_age  <= '0;
      hi_prev  <= 1'b0;
    end else begin
      hi_prev <= bit_hi;
      if (bit_hi) begin
        low_held <= 1'b0;
        low_age  <= '0;
      end else if (!low_held) begin
        low_held <= 1'b1;
        low_age  <= 4'd1;
      end else begin
        low_age  <= age_step(low_age, AGE_LIM);
      end
    end
  end

  // R2
  short_low_chk: assert property (@(posedge clk) disable iff (rst)
    qual_edge |-> ($past(!bit_hi, 1) && $past(!bit_hi, 2) && $past(!bit_hi, 3)));

  // R3
  second_high_chk: assert property (@(posedge clk) disable iff (rst)
    (bit_hi && hi_prev) |-> !qual_edge);

endmodule

// File: rtl/line_count_unit.sv
module line_count_unit #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             qual_edge,
  input  logic             wr_val,
  input  logic             wr_req,
  input  logic [CNT_W-1:0] wr_data,
  output logic             zero_after
);
  import line_irq_pkg::*;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] reload_val;
  logic             reload_pend;
  logic [CNT_W-1:0] cnt_next;
  logic             takes_reload;

  assign takes_reload = (cnt == '0) || reload_pend;
  assign cnt_next     = CNT_W'(next_count(8'(cnt), 8'(reload_val), reload_pend));
  assign zero_after   = qual_edge && (cnt_next == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt         <= '0;
      reload_val  <= '0;
      reload_pend <= 1'b0;
    end else begin
      if (qual_edge) cnt <= cnt_next;
      if (wr_val) reload_val <= wr_data;
      if (wr_req)         reload_pend <= 1'b1;
      else if (qual_edge) reload_pend <= 1'b0;
    end
  end

  // R4
  reload_load_chk: assert property (@(posedge clk) disable iff (rst)
    (qual_edge && takes_reload) |=> (cnt == $past(reload_val)));

  // R5
  decrement_chk: assert property (@(posedge clk) disable iff (rst)
    (qual_edge && !takes_reload) |=> (cnt == $past(cnt) - 1'b1));

  // R6
  req_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (qual_edge && !wr_req) |=> !reload_pend);

endmodule

// File: rtl/line_irq_ctrl.sv
module line_irq_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic zero_after,
  input  logic qual_edge,
  input  logic wr_off,
  input  logic wr_on,
  output logic irq_req
);
  logic irq_en;
  logic raise;

  assign raise = zero_after && irq_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_en  <= 1'b0;
      irq_req <= 1'b0;
    end else begin
      if (wr_off)     irq_en <= 1'b0;
      else if (wr_on) irq_en <= 1'b1;
      if (wr_off)     irq_req <= 1'b0;
      else if (raise) irq_req <= 1'b1;
    end
  end

  // R8
  ack_drop_chk: assert property (@(posedge clk) disable iff (rst)
    wr_off |=> !irq_req);

  // R7
  rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_req) |-> $past(qual_edge));

  // R7
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_req && !wr_off) |=> irq_req);

endmodule

// File: rtl/line_irq_timer.sv
module line_irq_timer #(
  parameter int ADDR_W    = 14,
  parameter int WATCH_BIT = 12,
  parameter int MIN_LOW   = 3,
  parameter int CNT_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] vaddr,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [CNT_W-1:0]  wr_data,
  output logic              irq_req
);
  import line_irq_pkg::*;

  logic qual_edge;
  logic zero_after;
  logic wr_val, wr_req, wr_off, wr_on;

  assign wr_val = wr_en && (wr_sel == SEL_RELOAD_VAL);
  assign wr_req = wr_en && (wr_sel == SEL_RELOAD_REQ);
  assign wr_off = wr_en && (wr_sel == SEL_IRQ_OFF);
  assign wr_on  = wr_en && (wr_sel == SEL_IRQ_ON);

  line_edge_filter #(.ADDR_W(ADDR_W), .WATCH_BIT(WATCH_BIT), .MIN_LOW(MIN_LOW)) u_filt (
    .clk(clk), .rst(rst), .vaddr(vaddr), .qual_edge(qual_edge));

  line_count_unit #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .qual_edge(qual_edge), .wr_val(wr_val),
    .wr_req(wr_req), .wr_data(wr_data), .zero_after(zero_after));

  line_irq_ctrl u_irq (
    .clk(clk), .rst(rst), .zero_after(zero_after), .qual_edge(qual_edge),
    .wr_off(wr_off), .wr_on(wr_on), .irq_req(irq_req));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> !irq_req);

endmodule

// File: tb/sim_line_irq_timer.sv
`timescale 1ns/1ps
module sim_line_irq_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [13:0] vaddr = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [7:0]  wr_data = '0;
  logic        irq_req;

  int n_chk = 0;
  int n_bad = 0;

  // reference model state
  int   m_run = 0;
  logic [7:0] m_cnt = '0, m_rv = '0;
  logic m_pend = 0, m_en = 0, m_irq = 0;

  always #4 clk = ~clk;

  line_irq_timer u0 (.clk(clk), .rst(rst), .vaddr(vaddr), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .irq_req(irq_req));

  function automatic bit counts_edge(input bit hi, input int run);
    return hi && (run >= 3);
  endfunction

  function automatic logic [7:0] model_count(input logic [7:0] c, input logic [7:0] rv,
                                             input logic p);
    if (p || c == 0) return rv;
    return c - 8'd1;
  endfunction

  task automatic check(input string req, input logic exp);
    n_chk++;
    if (irq_req !== exp) begin
      n_bad++;
      $display("FAIL %s irq_req actual=%b expected=%b at %0t", req, irq_req, exp, $time);
    end
  endtask

  task automatic step(input logic [13:0] a, input bit we, input logic [1:0] s,
                      input logic [7:0] d);
    bit e, set;
    logic [7:0] nc;
    @(negedge clk);
    vaddr = a; wr_en = we; wr_sel = s; wr_data = d;
    @(posedge clk);
    e = counts_edge(a[12], m_run);
    m_run = a[12] ? 0 : (m_run < 100 ? m_run + 1 : m_run);
    set = 0;
    if (e) begin
      nc = model_count(m_cnt, m_rv, m_pend);
      m_cnt = nc; m_pend = 0;
      set = (nc == 0) && m_en;
    end
    if (we && s == 2'd0) m_rv = d;
    if (we && s == 2'd1) m_pend = 1;
    m_irq = (m_irq || set) && !(we && s == 2'd2);
    if (we && s == 2'd2) m_en = 0;
    if (we && s == 2'd3) m_en = 1;
    #2;
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    step(14'h0000, 1, s, d);
  endtask

  task automatic line_edge(input int lows);
    for (int i = 0; i < lows; i++) step(14'h0000, 0, 0, 0);
    step(14'h1000, 0, 0, 0);
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 check("R1", 1'b0);
    @(negedge clk); rst = 1'b0;
    #1 check("R1", 1'b0);

    // reload 2, enable; edges: reload ->2, ->1, ->0 irq
    wr(2'd0, 8'd2); wr(2'd3, 0);
    line_edge(3); check("R4", m_irq);
    line_edge(3); check("R5", m_irq);
    line_edge(2); check("R2", m_irq);          // too short: no edge
    step(14'h1000, 0, 0, 0); check("R3", m_irq);
    line_edge(4); check("R7", 1'b1);
    step(14'h1000, 0, 0, 0); check("R7", 1'b1); // held
    wr(2'd2, 0); check("R8", 1'b0);
    // other bits toggle while bit 12 low: no edge
    wr(2'd3, 0);
    for (int i = 0; i < 8; i++) step(14'h2FFF & 14'(i * 13'h155), 0, 0, 0);
    check("R9", m_irq);
    // reload request forces reload from zero path
    wr(2'd0, 8'd1); wr(2'd1, 0);
    line_edge(3); check("R6", m_irq);
    line_edge(3); check("R7", m_irq);
    // disable in same cycle as edge
    wr(2'd2, 0); wr(2'd3, 0); wr(2'd0, 8'd0); wr(2'd1, 0); wr(2'd0, 8'd0);
    step(14'h0000, 0, 0, 0); step(14'h0000, 0, 0, 0);
    step(14'h1000, 1, 2'd2, 0); check("R8", 1'b0);

    // constrained random
    void'($urandom(32'd1234));
    for (int i = 0; i < 6000; i++) begin
      logic [13:0] a;
      bit we;
      a = 14'($urandom) & 14'h2FFF;
      if (($urandom % 5) == 0) a[12] = 1'b1;
      we = (($urandom % 10) == 0);
      step(a, we, 2'($urandom), 8'($urandom % 4));
      check((i % 2) ? "R4" : "R5", m_irq);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule